// File: doc/BRIEF.md
# Data-Processing Execute Unit

This block is the execute stage of a 32-bit load/store core, limited to arithmetic and move instructions. Each cycle in which `valid_i` is high, it takes one instruction word. It decodes the register fields and reads a sixteen-entry register file combinationally. It then builds the second operand, either from a register or from an 8-bit constant rotated right with wrap. Finally it computes a move, move-not, add, subtract or reverse subtract.

The computed value appears on `result_o` in the same cycle. It is committed to the destination register on the next rising clock edge, and only when the instruction is legal and its condition field means "always". An instruction whose condition is not "always" still drives its value on `result_o`. This lets a caller read any register without disturbing state.

Top module: `dp_exec_unit`

## Requirements
- R1: Asserting `rst_ni` low clears all sixteen registers to zero, asynchronously.
- R2: Add (opcode 0100) writes the first source plus the second operand, modulo 2^32.
- R3: Subtract (opcode 0010) writes the first source minus the second operand, modulo 2^32.
- R4: Reverse subtract (opcode 0011) writes the second operand minus the first source, modulo 2^32.
- R5: Move (opcode 1101) writes the second operand, and move-not (opcode 1111) writes its bitwise inverse. For both, the first-source field has no effect.
- R6: When bit 25 is 1, the second operand is bits 7:0 zero-extended and rotated right, with wrap, by twice bits 11:8; a count of 14 therefore acts as a left rotate by 4. When bit 25 is 0, the second operand is the register named by bits 3:0.
- R7: Fields: condition in bits 31:28, opcode in bits 24:21, first source in bits 19:16, destination in bits 15:12.
- R8: With `valid_i` high, an opcode outside the five above, or bits 27:26 not equal to 00, drives `illegal_o` high for that cycle and suppresses the write.
- R9: A legal instruction whose condition field is not 1110 performs no write and does not raise `illegal_o`. `result_o` still carries the computed value.
- R10: A legal instruction with condition 1110 asserts `wr_en_o` with `wr_addr_o` equal to the destination. The register takes `result_o` on the next rising edge. A read of that register in the same cycle sees the old value.
- R11: While `valid_i` is low, there is no write and `illegal_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction word present this cycle |
| instr_i | input | 32 | Instruction word |
| result_o | output | 32 | Computed value of the current instruction |
| wr_en_o | output | 1 | Result is committed at the next rising edge |
| wr_addr_o | output | 4 | Destination register index |
| illegal_o | output | 1 | Undecodable instruction pulse |

## Verification
A register write and a read of the same register can fall in the same cycle, for example when an instruction names its own destination as a source, such as an add of r3 to r3 into r3. The bench issues such instructions, both directed and in random streams that often reuse register indices. It judges them by checking `result_o` against the pre-write model value. It also issues back-to-back dependent instructions and checks that the following cycle sees the freshly written value.

// File: rtl/dp_exec_pkg.sv
package dp_exec_pkg;
  localparam int unsigned XLEN   = 32;
  localparam int unsigned NREG   = 16;
  localparam int unsigned AW     = $clog2(NREG);
  localparam int unsigned IMM_W  = 8;
  localparam int unsigned ROT_W  = 4;
  localparam int unsigned CON_W  = 4;

  localparam int unsigned COND_LSB = 28;
  localparam int unsigned CLS_LSB  = 26;
  localparam int unsigned IMMB_POS = 25;
  localparam int unsigned OPC_LSB  = 21;
  localparam int unsigned RN_LSB   = 16;
  localparam int unsigned RD_LSB   = 12;
  localparam int unsigned RM_LSB   = 0;
  localparam int unsigned ROT_LSB  = IMM_W;

  localparam logic [CON_W-1:0] COND_ALWAYS = 4'b1110;

  typedef enum logic [3:0] {
    OP_SUB = 4'b0010,
    OP_RSB = 4'b0011,
    OP_ADD = 4'b0100,
    OP_MOV = 4'b1101,
    OP_MVN = 4'b1111
  } alu_op_e;

  typedef struct packed {
    logic [3:0]       opc;
    logic [AW-1:0]    rd;
    logic [AW-1:0]    rn;
    logic [AW-1:0]    rm;
    logic             use_imm;
    logic [IMM_W-1:0] imm8;
    logic [ROT_W-1:0] rot;
    logic             legal;
    logic             cond_ok;
  } dec_t;
endpackage

// File: rtl/dp_decode.sv
module dp_decode
  import dp_exec_pkg::*;
(
  input  logic [XLEN-1:0] instr_i,
  output dec_t            dec_o
);
  logic [3:0] opc;
  logic       opc_ok;

  assign opc = instr_i[OPC_LSB +: 4];

  always_comb begin
    unique case (opc)
      OP_SUB, OP_RSB, OP_ADD, OP_MOV, OP_MVN: opc_ok = 1'b1;
      default:                                opc_ok = 1'b0;
    endcase
  end

  always_comb begin
    dec_o.opc     = opc;
    dec_o.rd      = instr_i[RD_LSB +: AW];
    dec_o.rn      = instr_i[RN_LSB +: AW];
    dec_o.rm      = instr_i[RM_LSB +: AW];
    dec_o.use_imm = instr_i[IMMB_POS];
    dec_o.imm8    = instr_i[0 +: IMM_W];
    dec_o.rot     = instr_i[ROT_LSB +: ROT_W];
    dec_o.legal   = opc_ok && (instr_i[CLS_LSB +: 2] == 2'b00);
    dec_o.cond_ok = instr_i[COND_LSB +: CON_W] == COND_ALWAYS;
  end
endmodule

// File: rtl/dp_operand.sv
module dp_operand
  import dp_exec_pkg::*;
(
  input  logic             use_imm_i,
  input  logic [IMM_W-1:0] imm8_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic [XLEN-1:0]  rm_data_i,
  output logic [XLEN-1:0]  op2_o
);
  localparam int unsigned SH_W = ROT_W + 1;

  logic [XLEN-1:0]   imm_zx;
  logic [SH_W-1:0]   sh_amt;
  logic [2*XLEN-1:0] dbl;
  logic [XLEN-1:0]   imm_rot;

  assign imm_zx  = {{(XLEN-IMM_W){1'b0}}, imm8_i};
  assign sh_amt  = {rot_i, 1'b0};
  // rotate right: shift a doubled copy, keep the low half
  assign dbl     = {imm_zx, imm_zx} >> sh_amt;
  assign imm_rot = dbl[XLEN-1:0];
  assign op2_o   = use_imm_i ? imm_rot : rm_data_i;
endmodule

// File: rtl/dp_alu.sv
module dp_alu
  import dp_exec_pkg::*;
(
  input  logic [3:0]      opc_i,
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  output logic [XLEN-1:0] y_o
);
  always_comb begin
    unique case (opc_i)
      OP_ADD:  y_o = a_i + b_i;
      OP_SUB:  y_o = a_i - b_i;
      OP_RSB:  y_o = b_i - a_i;
      OP_MOV:  y_o = b_i;
      OP_MVN:  y_o = ~b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/dp_regfile.sv
module dp_regfile
  import dp_exec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [AW-1:0]   waddr_i,
  input  logic [XLEN-1:0] wdata_i,
  input  logic [AW-1:0]   raddr_a_i,
  input  logic [AW-1:0]   raddr_b_i,
  output logic [XLEN-1:0] rdata_a_o,
  output logic [XLEN-1:0] rdata_b_o
);
  logic [XLEN-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          mem_q[g] <= '0;
      else if (we_i && waddr_i == AW'(g))   mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  logic            last_we_q;
  logic [AW-1:0]   last_addr_q;
  logic [XLEN-1:0] last_data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_we_q   <= 1'b0;
      last_addr_q <= '0;
      last_data_q <= '0;
    end else begin
      last_we_q   <= we_i;
      last_addr_q <= waddr_i;
      last_data_q <= wdata_i;
    end
  end

  // R10: a committed write is visible the cycle after
  p_write_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_we_q |-> mem_q[last_addr_q] == last_data_q);
endmodule

// File: rtl/dp_exec_unit.sv
module dp_exec_unit
  import dp_exec_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic [31:0]     instr_i,
  output logic [31:0]     result_o,
  output logic            wr_en_o,
  output logic [3:0]      wr_addr_o,
  output logic            illegal_o
);
  dec_t            dec;
  logic [XLEN-1:0] rn_data;
  logic [XLEN-1:0] rm_data;
  logic [XLEN-1:0] op2;
  logic [XLEN-1:0] alu_y;

  dp_decode i_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  dp_regfile i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_en_o),
    .waddr_i   (dec.rd),
    .wdata_i   (alu_y),
    .raddr_a_i (dec.rn),
    .raddr_b_i (dec.rm),
    .rdata_a_o (rn_data),
    .rdata_b_o (rm_data)
  );

  dp_operand i_opnd (
    .use_imm_i (dec.use_imm),
    .imm8_i    (dec.imm8),
    .rot_i     (dec.rot),
    .rm_data_i (rm_data),
    .op2_o     (op2)
  );

  dp_alu i_alu (
    .opc_i (dec.opc),
    .a_i   (rn_data),
    .b_i   (op2),
    .y_o   (alu_y)
  );

  assign result_o  = alu_y;
  assign wr_addr_o = dec.rd;
  assign wr_en_o   = valid_i && dec.legal && dec.cond_ok;
  assign illegal_o = valid_i && !dec.legal;

  // R8
  p_illegal_no_write_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> !wr_en_o);
  // R11
  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |-> (!wr_en_o && !illegal_o));
  // R9
  p_cond_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[31:28] != 4'b1110) |-> !wr_en_o);
  // R6
  p_imm_norot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && instr_i[25] && instr_i[11:8] == 4'd0) |->
      op2 == {{(XLEN-8){1'b0}}, instr_i[7:0]});
  // R2
  p_add_inverse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec.opc == OP_ADD) |-> (result_o - op2) == rn_data);
  // R4
  p_rsb_mirror_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec.opc == OP_RSB) |-> (result_o + rn_data) == op2);
endmodule

// File: tb/test_dp_exec_unit.sv
module test_dp_exec_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] instr_i = '0;
  logic [31:0] result_o;
  logic        wr_en_o;
  logic [3:0]  wr_addr_o;
  logic        illegal_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] model [16];

  always #2.5 clk_i = ~clk_i;

  dp_exec_unit i_dp_exec_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .instr_i(instr_i),
    .result_o(result_o), .wr_en_o(wr_en_o), .wr_addr_o(wr_addr_o),
    .illegal_o(illegal_o)
  );

  function automatic logic [31:0] enc(logic [3:0] c, logic i, logic [3:0] op,
                                      logic [3:0] rn, logic [3:0] rd, logic [11:0] f);
    return {c, 2'b00, i, op, 1'b0, rn, rd, f};
  endfunction

  function automatic logic [31:0] ror32(logic [31:0] v, int unsigned n);
    logic [31:0] r;
    r = v;
    for (int k = 0; k < int'(n); k++) r = {r[0], r[31:1]};
    return r;
  endfunction

  function automatic bit op_legal(logic [3:0] op);
    return op == 4'b0010 || op == 4'b0011 || op == 4'b0100 ||
           op == 4'b1101 || op == 4'b1111;
  endfunction

  function automatic logic [31:0] exp_op2(logic [31:0] ins);
    if (ins[25]) return ror32({24'd0, ins[7:0]}, 2 * ins[11:8]);
    return model[ins[3:0]];
  endfunction

  function automatic logic [31:0] exp_res(logic [31:0] ins);
    logic [31:0] a, b;
    a = model[ins[19:16]];
    b = exp_op2(ins);
    case (ins[24:21])
      4'b0100: return a + b;
      4'b0010: return a - b;
      4'b0011: return b - a;
      4'b1101: return b;
      4'b1111: return ~b;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  task automatic issue(logic [31:0] ins, logic v, string tag);
    bit legal, we;
    @(negedge clk_i);
    valid_i = v;
    instr_i = ins;
    #1;
    legal = op_legal(ins[24:21]) && ins[27:26] == 2'b00;
    we    = v && legal && ins[31:28] == 4'b1110;
    chk({tag, " wr_en"}, {31'd0, wr_en_o}, {31'd0, we});
    chk({tag, " illegal"}, {31'd0, illegal_o}, {31'd0, v && !legal});
    if (v && legal) chk({tag, " result"}, result_o, exp_res(ins));
    if (we) chk({tag, " wr_addr"}, {28'd0, wr_addr_o}, {28'd0, ins[15:12]});
    @(posedge clk_i);
    if (we) model[ins[15:12]] = exp_res(ins);
  endtask

  // read register k with a never-condition move: no write
  task automatic peek(int k, string tag);
    issue(enc(4'b0000, 1'b0, 4'b1101, 4'd0, 4'd0, 12'(k)), 1'b1, tag);
  endtask

  task automatic peek_all(string tag);
    for (int k = 0; k < 16; k++) peek(k, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 16; k++) model[k] = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    peek_all("R1 reset");

    // immediates and moves
    issue(enc(4'hE, 1'b1, 4'b1101, 4'd0, 4'd1, {4'd14, 8'h32}), 1'b1, "R6 rot14");
    chk("R6 rot14 value", model[1], 32'h0000_0320);
    issue(enc(4'hE, 1'b1, 4'b1101, 4'd0, 4'd2, {4'd1, 8'hFF}), 1'b1, "R6 rot1");
    chk("R6 rot1 value", model[2], 32'hC000_003F);
    issue(enc(4'hE, 1'b1, 4'b1111, 4'd9, 4'd3, {4'd0, 8'h00}), 1'b1, "R5 mvn");
    issue(enc(4'hE, 1'b0, 4'b1101, 4'd7, 4'd4, 12'd2), 1'b1, "R5 mov reg");
    // add wrap: r3 = ffffffff + 1
    issue(enc(4'hE, 1'b1, 4'b0100, 4'd3, 4'd5, {4'd0, 8'h01}), 1'b1, "R2 add wrap");
    chk("R2 wrap value", model[5], 32'd0);
    issue(enc(4'hE, 1'b0, 4'b0010, 4'd5, 4'd6, 12'd1), 1'b1, "R3 sub under");
    issue(enc(4'hE, 1'b1, 4'b0011, 4'd1, 4'd7, {4'd0, 8'h05}), 1'b1, "R4 rsb imm");
    chk("R4 rsb value", model[7], 32'd5 - 32'h320);
    // same-cycle read of the destination, then dependent follower
    issue(enc(4'hE, 1'b0, 4'b0100, 4'd1, 4'd1, 12'd1), 1'b1, "R10 self add");
    issue(enc(4'hE, 1'b0, 4'b1101, 4'd0, 4'd8, 12'd1), 1'b1, "R10 dependent");
    chk("R10 dependent value", model[8], 32'h0000_0640);
    // illegal, cond, idle
    issue(enc(4'hE, 1'b0, 4'b0000, 4'd1, 4'd1, 12'd1), 1'b1, "R8 bad opcode");
    issue(enc(4'hE, 1'b0, 4'b0100, 4'd1, 4'd1, 12'd1) | 32'h0400_0000, 1'b1, "R8 bad class");
    issue(enc(4'h0, 1'b1, 4'b1101, 4'd0, 4'd1, 12'hFF), 1'b1, "R9 cond never");
    issue(enc(4'hE, 1'b1, 4'b1101, 4'd0, 4'd1, 12'hAB), 1'b0, "R11 idle");
    peek_all("R7 R8 R9 R11 readback");

    for (int n = 0; n < 400; n++) begin
      logic [3:0] c, op;
      logic [31:0] ins;
      logic [3:0] legal_ops [5] = '{4'b0010, 4'b0011, 4'b0100, 4'b1101, 4'b1111};
      c  = ($urandom % 8 == 0) ? 4'($urandom) : 4'hE;
      op = ($urandom % 10 == 0) ? 4'($urandom) : legal_ops[$urandom % 5];
      ins = enc(c, 1'($urandom), op, 4'($urandom % 4), 4'($urandom % 4), 12'($urandom));
      if ($urandom % 20 == 0) ins[27:26] = 2'($urandom);
      issue(ins, ($urandom % 8) != 0, "R2 R3 R4 R5 R6 R10 random");
    end
    peek_all("R10 random readback");

    // mid-run reset
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    for (int k = 0; k < 16; k++) model[k] = '0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    peek_all("R1 async reset");

    done = 1;
    summary();
    $finish;
  end
endmodule